// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between an interrupt controller and a processor core. Every clock cycle it decides whether the core must take an exception. Three kinds of request compete for that decision: a restart request, a non-maskable request and a maskable request carrying a 3-bit priority level. The core feeds back its current mask level and interrupt-enable bit. When a request wins, the block emits a one-cycle take strobe together with:

- the kind of request taken;
- the handler address;
- the new mask level and enable bit the core must load;
- the stack offsets at which the core saves the return address and the status word.

Maskable handler addresses are a fixed base plus a 16-bit offset held in a per-level vector register. Software programs these offsets through a small bus-mapped register block.

Restart and non-maskable requests are single pulses. The block latches them until they are served. A maskable level is a level signal: the block samples it every cycle and never clears it. It stays pending until the controller drives another value, and value 7 means "nothing pending". The decision is registered, so outputs appear one cycle after the state that produced them.

Top module: `irq_accept_unit`

## Requirements
- R1: Priority is fixed: a latched restart request beats a latched non-maskable request, which beats a maskable level. A restart take reports kind 1, handler address RESTART_PC (default 0x0000_0000), new mask level 7, new enable 0, no acknowledge and zero push offsets.
- R2: A pulse on restart_req or nmi_req is remembered until it is taken, and each pulse leads to exactly one take. A pulse that arrives in the same cycle as the take of the same kind is kept for a later take.
- R3: A non-maskable take reports kind 2, handler address 0x4000_0008, new mask level equal to the current psw_lm, and new enable 0.
- R4: The pending level is sampled from lvl_pend every cycle and resets to 7. A maskable take (kind 3) happens only when psw_ie is 1 and the sampled level is numerically below psw_lm, so level 7 is never taken. take_kind encodes 0 none, 1 restart, 2 non-maskable, 3 maskable.
- R5: A maskable take reports handler address 0x4000_0000 plus the zero-extended vector register of that level, using the value held before any bus write in the same cycle. It also reports new mask level equal to the accepted level and new enable 0.
- R6: ack_valid pulses together with every maskable take and only then, with ack_level equal to the accepted level.
- R7: Accepting a maskable level does not clear it. If the core later restores a mask that allows it, the same level is taken again without any new event from the controller.
- R8: Vector register k (0..6) sits at byte offset 4*k. A write updates it only when bus_bytes equals 2. Writes with any other size, and writes to any other offset, change nothing. bus_wdata[7:0] is the byte at the lower address, i.e. the low byte of the value.
- R9: A read returns data on bus_rdata in the cycle after bus_rd. Offset 4*k returns vector k, offset 0x20 returns CTRL_VAL (0x0000), offset 0x40 returns MODE_VAL (0x0003), and any other offset returns 0. bus_rdata is 0 in a cycle that follows no read.
- R10: Non-maskable and maskable takes report a return-address push offset of 4 and a status-word push offset of 8. In all other cycles both offsets are 0.
- R11: After reset there is no take and no acknowledge, read data is 0, all vector registers are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart_req | input | 1 | Restart request pulse |
| nmi_req | input | 1 | Non-maskable request pulse |
| lvl_pend | input | 3 | Pending maskable level, 7 = none |
| psw_lm | input | 3 | Core's current mask level |
| psw_ie | input | 1 | Core's interrupt-enable bit |
| bus_addr | input | 7 | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_bytes | input | 3 | Access size in bytes |
| bus_wdata | input | 16 | Write data, little-endian |
| bus_rdata | output | 16 | Read data, one cycle after bus_rd |
| take | output | 1 | One-cycle take strobe |
| take_kind | output | 2 | Kind of request taken |
| take_pc | output | 32 | Handler address |
| new_lm | output | 3 | Mask level to load |
| new_ie | output | 1 | Enable bit to load |
| ack_valid | output | 1 | Maskable acknowledge strobe |
| ack_level | output | 3 | Acknowledged level |
| pc_push_off | output | 4 | Return-address save offset below SP |
| psw_push_off | output | 4 | Status-word save offset below SP |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is arbitration against latching. Restart, non-maskable and an eligible maskable level are raised together, and a fresh nmi_req pulse is driven in the very cycle an older one is taken. The bench then expects restart first, non-maskable next and the level last, and it expects a second non-maskable take for the fresh pulse.

The second pair is a bus write to the vector register of the level being taken, in the same cycle as the take. The take must carry the old offset, and a later read must return the new one.

Beyond these directed cases, a reference model fed with random pulses, levels, masks and bus traffic predicts every output in every cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    // Kind of exception reported with the take strobe
    typedef enum logic [1:0] {
        TK_NONE    = 2'd0,
        TK_RESTART = 2'd1,
        TK_NMI     = 2'd2,
        TK_LEVEL   = 2'd3
    } take_kind_e;

endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs #(
    parameter int                   NUM_VEC  = 7,
    parameter int                   VEC_W    = 16,
    parameter int                   ADDR_W   = 7,
    parameter int                   SIZE_W   = 3,
    parameter int                   WR_BYTES = 2,
    parameter logic [ADDR_W-1:0]    CTRL_OFF = 7'h20,
    parameter logic [ADDR_W-1:0]    MODE_OFF = 7'h40,
    parameter logic [VEC_W-1:0]     CTRL_VAL = 16'h0000,
    parameter logic [VEC_W-1:0]     MODE_VAL = 16'h0003
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [SIZE_W-1:0]             bus_bytes,
    input  logic [VEC_W-1:0]              bus_wdata,
    output logic [VEC_W-1:0]              bus_rdata,
    output logic [NUM_VEC-1:0][VEC_W-1:0] vec_out
);

    localparam logic [SIZE_W-1:0] WR_SIZE = SIZE_W'(WR_BYTES);

    typedef struct packed {
        logic [NUM_VEC-1:0][VEC_W-1:0] vec;
        logic [VEC_W-1:0]              rdata;
    } regs_t;

    regs_t s_d, s_q;

    // One address comparator per vector register, stride of four bytes
    logic [NUM_VEC-1:0] hit;
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_dec
        assign hit[g] = (bus_addr == ADDR_W'(4 * g));
    end

    logic wr_ok;
    assign wr_ok = bus_wr && (bus_bytes == WR_SIZE);

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        if (bus_rd) begin
            for (int k = 0; k < NUM_VEC; k++) begin
                if (hit[k]) begin
                    s_d.rdata = s_q.vec[k];
                end
            end
            if (bus_addr == CTRL_OFF) begin
                s_d.rdata = CTRL_VAL;
            end
            if (bus_addr == MODE_OFF) begin
                s_d.rdata = MODE_VAL;
            end
        end
        if (wr_ok) begin
            for (int k = 0; k < NUM_VEC; k++) begin
                if (hit[k]) begin
                    s_d.vec[k] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign vec_out   = s_q.vec;

    AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_bytes != WR_SIZE)) |=> $stable(vec_out)) else $error("size"); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)) else $error("idle rdata"); // R9

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int               LVL_W      = 3,
    parameter int               NUM_VEC    = 7,
    parameter int               VEC_W      = 16,
    parameter int               PC_W       = 32,
    parameter int               OFF_W      = 4,
    parameter int               PC_PUSH    = 4,
    parameter int               PSW_PUSH   = 8,
    parameter logic [PC_W-1:0]  VEC_BASE   = 32'h4000_0000,
    parameter logic [PC_W-1:0]  NMI_PC     = 32'h4000_0008,
    parameter logic [PC_W-1:0]  RESTART_PC = 32'h0000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart_req,
    input  logic                          nmi_req,
    input  logic [LVL_W-1:0]              lvl_in,
    input  logic [LVL_W-1:0]              psw_lm,
    input  logic                          psw_ie,
    input  logic [NUM_VEC-1:0][VEC_W-1:0] vec_in,
    output logic                          take,
    output take_kind_e                    kind,
    output logic [PC_W-1:0]               take_pc,
    output logic [LVL_W-1:0]              new_lm,
    output logic                          new_ie,
    output logic                          ack_valid,
    output logic [LVL_W-1:0]              ack_level,
    output logic [OFF_W-1:0]              pc_push_off,
    output logic [OFF_W-1:0]              psw_push_off
);

    localparam logic [LVL_W-1:0] NO_REQ = LVL_W'((1 << LVL_W) - 1);

    typedef struct packed {
        logic             rst_p;
        logic             nmi_p;
        logic [LVL_W-1:0] lvl;
        logic             take;
        take_kind_e       kind;
        logic [PC_W-1:0]  pc;
        logic [LVL_W-1:0] lm;
        logic             ie;
        logic             ack;
        logic [LVL_W-1:0] ack_lvl;
        logic [OFF_W-1:0] pc_off;
        logic [OFF_W-1:0] psw_off;
    } arb_t;

    arb_t s_d, s_q;
    logic lvl_ok;

    always_comb begin
        lvl_ok      = psw_ie && (s_q.lvl < psw_lm);
        s_d         = s_q;
        s_d.lvl     = lvl_in;
        s_d.take    = 1'b0;
        s_d.kind    = TK_NONE;
        s_d.pc      = '0;
        s_d.lm      = '0;
        s_d.ie      = 1'b0;
        s_d.ack     = 1'b0;
        s_d.ack_lvl = '0;
        s_d.pc_off  = '0;
        s_d.psw_off = '0;
        if (s_q.rst_p) begin
            s_d.rst_p = 1'b0;
            s_d.take  = 1'b1;
            s_d.kind  = TK_RESTART;
            s_d.pc    = RESTART_PC;
            s_d.lm    = NO_REQ;
        end else if (s_q.nmi_p) begin
            s_d.nmi_p   = 1'b0;
            s_d.take    = 1'b1;
            s_d.kind    = TK_NMI;
            s_d.pc      = NMI_PC;
            s_d.lm      = psw_lm;
            s_d.pc_off  = OFF_W'(PC_PUSH);
            s_d.psw_off = OFF_W'(PSW_PUSH);
        end else if (lvl_ok) begin
            s_d.take    = 1'b1;
            s_d.kind    = TK_LEVEL;
            s_d.pc      = VEC_BASE + PC_W'(vec_in[s_q.lvl]);
            s_d.lm      = s_q.lvl;
            s_d.ack     = 1'b1;
            s_d.ack_lvl = s_q.lvl;
            s_d.pc_off  = OFF_W'(PC_PUSH);
            s_d.psw_off = OFF_W'(PSW_PUSH);
        end
        // A new pulse is never lost, even in the cycle of its own take
        s_d.rst_p = s_d.rst_p | restart_req;
        s_d.nmi_p = s_d.nmi_p | nmi_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.lvl <= NO_REQ;
        end else begin
            s_q <= s_d;
        end
    end

    assign take         = s_q.take;
    assign kind         = s_q.kind;
    assign take_pc      = s_q.pc;
    assign new_lm       = s_q.lm;
    assign new_ie       = s_q.ie;
    assign ack_valid    = s_q.ack;
    assign ack_level    = s_q.ack_lvl;
    assign pc_push_off  = s_q.pc_off;
    assign psw_push_off = s_q.psw_off;

    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind != TK_RESTART) |-> !$past(s_q.rst_p)) else $error("prio"); // R1

    AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == TK_NMI) |-> (!s_q.nmi_p || $past(nmi_req))) else $error("nmi clr"); // R2

    AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == TK_LEVEL) |-> ($past(psw_ie) && (ack_level < $past(psw_lm))))
        else $error("mask"); // R4

    AST_ACK_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_level == $past(s_q.lvl))) else $error("ack"); // R6

    AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == TK_LEVEL) |-> (s_q.lvl == $past(lvl_in))) else $error("keep"); // R7

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int               LVL_W      = 3,
    parameter int               VEC_W      = 16,
    parameter int               ADDR_W     = 7,
    parameter int               SIZE_W     = 3,
    parameter int               PC_W       = 32,
    parameter int               OFF_W      = 4,
    parameter logic [PC_W-1:0]  VEC_BASE   = 32'h4000_0000,
    parameter logic [PC_W-1:0]  NMI_PC     = 32'h4000_0008,
    parameter logic [PC_W-1:0]  RESTART_PC = 32'h0000_0000,
    parameter logic [VEC_W-1:0] CTRL_VAL   = 16'h0000,
    parameter logic [VEC_W-1:0] MODE_VAL   = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_req,
    input  logic              nmi_req,
    input  logic [LVL_W-1:0]  lvl_pend,
    input  logic [LVL_W-1:0]  psw_lm,
    input  logic              psw_ie,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [SIZE_W-1:0] bus_bytes,
    input  logic [VEC_W-1:0]  bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata,
    output logic              take,
    output logic [1:0]        take_kind,
    output logic [PC_W-1:0]   take_pc,
    output logic [LVL_W-1:0]  new_lm,
    output logic              new_ie,
    output logic              ack_valid,
    output logic [LVL_W-1:0]  ack_level,
    output logic [OFF_W-1:0]  pc_push_off,
    output logic [OFF_W-1:0]  psw_push_off
);

    // One vector per level below the "nothing pending" code
    localparam int NUM_VEC = (1 << LVL_W) - 1;

    logic [NUM_VEC-1:0][VEC_W-1:0] vec_w;
    take_kind_e                    kind_w;

    irq_vec_regs #(
        .NUM_VEC  (NUM_VEC),
        .VEC_W    (VEC_W),
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .WR_BYTES (2),
        .CTRL_OFF (ADDR_W'(32)),
        .MODE_OFF (ADDR_W'(64)),
        .CTRL_VAL (CTRL_VAL),
        .MODE_VAL (MODE_VAL)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_bytes (bus_bytes),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .vec_out   (vec_w)
    );

    irq_arbiter #(
        .LVL_W      (LVL_W),
        .NUM_VEC    (NUM_VEC),
        .VEC_W      (VEC_W),
        .PC_W       (PC_W),
        .OFF_W      (OFF_W),
        .PC_PUSH    (4),
        .PSW_PUSH   (8),
        .VEC_BASE   (VEC_BASE),
        .NMI_PC     (NMI_PC),
        .RESTART_PC (RESTART_PC)
    ) arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_req  (restart_req),
        .nmi_req      (nmi_req),
        .lvl_in       (lvl_pend),
        .psw_lm       (psw_lm),
        .psw_ie       (psw_ie),
        .vec_in       (vec_w),
        .take         (take),
        .kind         (kind_w),
        .take_pc      (take_pc),
        .new_lm       (new_lm),
        .new_ie       (new_ie),
        .ack_valid    (ack_valid),
        .ack_level    (ack_level),
        .pc_push_off  (pc_push_off),
        .psw_push_off (psw_push_off)
    );

    assign take_kind = kind_w;

endmodule

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart_req = 1'b0, nmi_req = 1'b0;
    logic [2:0]  lvl_pend = 3'd7, psw_lm = 3'd7;
    logic        psw_ie = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_bytes = 3'd2;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        take, new_ie, ack_valid;
    logic [1:0]  take_kind;
    logic [31:0] take_pc;
    logic [2:0]  new_lm, ack_level;
    logic [3:0]  pc_push_off, psw_push_off;

    always #2 clk = ~clk;

    irq_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .nmi_req(nmi_req),
        .lvl_pend(lvl_pend), .psw_lm(psw_lm), .psw_ie(psw_ie),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_bytes(bus_bytes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .take(take), .take_kind(take_kind), .take_pc(take_pc),
        .new_lm(new_lm), .new_ie(new_ie), .ack_valid(ack_valid),
        .ack_level(ack_level), .pc_push_off(pc_push_off), .psw_push_off(psw_push_off)
    );

    int unsigned n_checks = 0, n_fail = 0;
    bit          finished = 1'b0;

    // Reference model state
    logic [15:0] m_vec [7];
    logic [2:0]  m_lvl = 3'd7;
    bit          m_rp = 1'b0, m_np = 1'b0;
    // Expected outputs for the next sample point
    bit          e_take, e_ie, e_ack;
    logic [1:0]  e_kind;
    logic [31:0] e_pc;
    logic [2:0]  e_lm, e_ackl;
    logic [3:0]  e_pco, e_pswo;
    logic [15:0] e_rd;
    bit          follow = 1'b1;
    string       kind_tag = "";
    string       rd_tag = "R9";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [6:0] a);
        if (a[1:0] == 2'b00 && a < 7'd28) return m_vec[a >> 2];
        if (a == 7'h20) return 16'h0000;
        if (a == 7'h40) return 16'h0003;
        return 16'h0000;
    endfunction

    function automatic string tag_of(logic [1:0] k);
        if (kind_tag != "") return kind_tag;
        case (k)
            2'd1:    return "R1";
            2'd2:    return "R3";
            2'd3:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic model_step();
        e_take = 0; e_kind = 0; e_pc = 0; e_lm = 0; e_ie = 0;
        e_ack = 0; e_ackl = 0; e_pco = 0; e_pswo = 0;
        if (m_rp) begin
            e_take = 1; e_kind = 2'd1; e_pc = 32'h0; e_lm = 3'd7; m_rp = 0;
        end else if (m_np) begin
            e_take = 1; e_kind = 2'd2; e_pc = 32'h4000_0008; e_lm = psw_lm;
            e_pco = 4; e_pswo = 8; m_np = 0;
        end else if (psw_ie && (m_lvl < psw_lm)) begin
            e_take = 1; e_kind = 2'd3; e_pc = 32'h4000_0000 + {16'h0, m_vec[m_lvl]};
            e_lm = m_lvl; e_ack = 1; e_ackl = m_lvl; e_pco = 4; e_pswo = 8;
        end
        e_rd = bus_rd ? exp_read(bus_addr) : 16'h0;
        if (bus_wr && bus_bytes == 3'd2 && bus_addr[1:0] == 2'b00 && bus_addr < 7'd28)
            m_vec[bus_addr >> 2] = bus_wdata;
        m_lvl = lvl_pend;
        m_rp  = m_rp | restart_req;
        m_np  = m_np | nmi_req;
    endtask

    // Called at a falling edge with stimulus set; returns at the next falling edge
    task automatic cycle();
        model_step();
        @(negedge clk);
        chk(tag_of(e_kind), "take", {31'h0, take}, {31'h0, e_take});
        chk(e_kind == 2'd1 ? "R1" : (e_kind == 2'd2 ? "R2" : "R4"), "kind",
            {30'h0, take_kind}, {30'h0, e_kind});
        chk(tag_of(e_kind), "pc", take_pc, e_pc);
        chk(tag_of(e_kind), "new_lm", {29'h0, new_lm}, {29'h0, e_lm});
        chk(tag_of(e_kind), "new_ie", {31'h0, new_ie}, {31'h0, e_ie});
        chk("R6", "ack", {28'h0, ack_valid, ack_level}, {28'h0, e_ack, e_ackl});
        chk("R10", "push offsets", {24'h0, pc_push_off, psw_push_off}, {24'h0, e_pco, e_pswo});
        chk(rd_tag, "rdata", {16'h0, bus_rdata}, {16'h0, e_rd});
        if (follow && e_take) begin
            psw_lm = e_lm;
            psw_ie = e_ie;
        end
        restart_req = 0; nmi_req = 0; bus_rd = 0; bus_wr = 0; bus_bytes = 3'd2;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] picks [10];
        picks = '{7'h00, 7'h04, 7'h08, 7'h0c, 7'h10, 7'h14, 7'h18, 7'h20, 7'h40, 7'h1c};
        void'($urandom(32'd20240611));
        for (int k = 0; k < 7; k++) m_vec[k] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "take after reset", {31'h0, take}, 32'h0);
        chk("R11", "ack after reset", {31'h0, ack_valid}, 32'h0);
        chk("R11", "rdata after reset", {16'h0, bus_rdata}, 32'h0);
        bus_rd = 1; bus_addr = 7'h0c; cycle();
        chk("R11", "vector 3 after reset", {16'h0, bus_rdata}, 32'h0);

        // R8: sized writes
        rd_tag = "R8";
        bus_wr = 1; bus_addr = 7'h0c; bus_wdata = 16'h1234; cycle();
        bus_wr = 1; bus_addr = 7'h0c; bus_bytes = 3'd1; bus_wdata = 16'hffff; cycle();
        bus_wr = 1; bus_addr = 7'h0c; bus_bytes = 3'd4; bus_wdata = 16'heeee; cycle();
        bus_wr = 1; bus_addr = 7'h0e; bus_wdata = 16'hdddd; cycle();
        bus_rd = 1; bus_addr = 7'h0c; cycle();
        chk("R8", "vector 3 keeps 16-bit write", {16'h0, bus_rdata}, 32'h1234);
        bus_wr = 1; bus_addr = 7'h08; bus_wdata = 16'h0200; cycle();
        rd_tag = "R9";
        bus_rd = 1; bus_addr = 7'h40; cycle();
        bus_rd = 1; bus_addr = 7'h20; cycle();
        bus_rd = 1; bus_addr = 7'h30; cycle();

        // R1/R2: all three at once, then fresh NMI during NMI take
        psw_lm = 3'd7; psw_ie = 1; lvl_pend = 3'd2;
        restart_req = 1; nmi_req = 1; cycle();
        cycle();                       // restart taken here
        chk("R1", "restart wins", {30'h0, take_kind}, 32'd1);
        nmi_req = 1; cycle();          // NMI taken while new pulse arrives
        chk("R2", "nmi second", {30'h0, take_kind}, 32'd2);
        cycle();
        chk("R2", "fresh nmi kept", {30'h0, take_kind}, 32'd2);
        // level 2 now eligible: write its vector in the same cycle as its take
        psw_lm = 3'd7; psw_ie = 1;
        bus_wr = 1; bus_addr = 7'h08; bus_wdata = 16'h0abc; cycle();
        chk("R5", "old vector used", take_pc, 32'h4000_0200);
        lvl_pend = 3'd7; idle(3);

        // R7: level stays pending across acceptance
        kind_tag = "R7";
        psw_lm = 3'd7; psw_ie = 1; lvl_pend = 3'd3; cycle();
        cycle();
        chk("R7", "first take", take_pc, 32'h4000_1234);
        idle(3);
        chk("R7", "masked while in handler", {31'h0, take}, 32'h0);
        psw_lm = 3'd7; psw_ie = 1; cycle();
        chk("R7", "retaken after mask restored", {29'h0, ack_level}, 32'd3);
        kind_tag = "";
        // R4: level equal to mask is refused, enable off refuses
        psw_lm = 3'd3; psw_ie = 1; idle(2);
        chk("R4", "equal level refused", {31'h0, take}, 32'h0);
        psw_lm = 3'd7; psw_ie = 0; idle(2);
        chk("R4", "enable off refuses", {31'h0, take}, 32'h0);
        lvl_pend = 3'd7; psw_ie = 1; idle(2);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 64 == 0) restart_req = 1;
            if ($urandom % 16 == 0) nmi_req = 1;
            if ($urandom % 8 == 0) lvl_pend = 3'($urandom % 8);
            if ($urandom % 10 == 0) begin
                psw_lm = 3'($urandom % 8);
                psw_ie = ($urandom % 4) != 0;
            end
            if ($urandom % 3 == 0) begin
                bus_rd = 1;
                bus_addr = ($urandom % 5 == 0) ? 7'($urandom) : picks[$urandom % 10];
            end
            if ($urandom % 4 == 0) begin
                bus_wr = 1;
                bus_addr = ($urandom % 5 == 0) ? 7'($urandom) : picks[$urandom % 10];
                bus_wdata = 16'($urandom);
                bus_bytes = ($urandom % 5 == 0) ? 3'($urandom % 5) : 3'd2;
            end
            cycle();
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule